// File: doc/BRIEF.md
# Receive Status and Interrupt Register

This block holds the eight status flags that a network controller's receive path reports to the host. Each flag is set by a hardware event and stays set until the host clears it. The events are: a new packet in the receive buffer, a stalled host read, the end of a DMA transfer, and five simple receive strobes. The five strobes report a remote reset request, a short packet, an alignment error, a CRC error and a buffer overflow. The host clears a flag by writing a 1 in its position. A write of 0 leaves the flag alone. An 8-bit enable mask selects which flags drive the single interrupt line.

Two flags have their own rules. The packet-ready flag comes back on its own after a clear if packets are still waiting in the buffer. The DMA-done flag ignores writes and is cleared only when both DMA enables are low. A small state machine watches host reads of the receive buffer. Its states are IDLE, WAIT and EXPIRE. A read of an empty buffer moves it from IDLE to WAIT. When the buffer reports data, WAIT returns to IDLE. When the timeout elapses, WAIT moves to EXPIRE. EXPIRE sets the read-error flag for one cycle and then returns to IDLE.

Top module: `rxs_status`

## Requirements
- R1: After reset, `status_o` and `mask_o` are 8'h00 and `irq_o` is 0.
- R2: Bits 4..0 of `status_o` are the remote reset, short packet, alignment error, CRC error and overflow flags, from bit 4 down to bit 0. Each is set on the clock edge that samples a 1 on the same bit of `ev_lo`, and it holds until cleared.
- R3: A clock edge with `wr_en`=1 clears every bit of `status_o` in positions 7, 6 and 4..0 where `wr_data` is 1. Bits where `wr_data` is 0 keep their value.
- R4: If a set event and a write-1 clear reach the same bit on the same edge, the bit is 1 afterwards.
- R5: `irq_o` is 1 exactly when some bit is 1 in both `status_o` and `mask_o`. The mask register loads `mask_wr_data` on an edge with `mask_wr_en`=1.
- R6: Bit 7 (packet ready) is set on the edge where `pkt_count` is greater than its value at the previous edge.
- R7: A write that clears bit 7 while `pkt_count` > 1 leaves bit 7 at 0 for one cycle, and bit 7 is 1 again one edge later. If `pkt_count` ≤ 1 at the clear, bit 7 stays 0.
- R8: Bit 6 (bus read error) covers a `host_rd` that is sampled with `buf_empty`=1. If `buf_empty` stays 1, bit 6 reads 1 after edge TIMEOUT_CYC+1, counted from that read edge, and reads 0 before it. If `buf_empty` falls first, or the read finds `buf_empty`=0, bit 6 is not set.
- R9: Bit 5 (DMA done) is set by `dma_eop` while `dma_rx_en` or `dma_tx_en` is 1. A write of 1 to bit 5 has no effect. When both enables are 0, bit 5 is 0 after the next edge, and a `dma_eop` on that edge does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_count | input | CNT_W | Good packets held in the receive buffer |
| host_rd | input | 1 | Host read strobe of the receive buffer |
| buf_empty | input | 1 | Receive buffer has no data to return |
| dma_eop | input | 1 | End-of-process strobe from the DMA controller |
| dma_rx_en | input | 1 | DMA receive enable |
| dma_tx_en | input | 1 | DMA transmit enable |
| ev_lo | input | 5 | Set strobes for status bits 4..0 |
| wr_en | input | 1 | Host write strobe for the status register |
| wr_data | input | 8 | Write-1-to-clear data |
| mask_wr_en | input | 1 | Host write strobe for the enable mask |
| mask_wr_data | input | 8 | New enable mask value |
| status_o | output | 8 | Status register |
| mask_o | output | 8 | Enable mask register |
| irq_o | output | 1 | Interrupt request |

## Verification
The five plain flags are driven with random event strobes, random write-1 clears and random mask writes at the same time. This shows whether set and clear are combined bit by bit, and whether a clear leaks into flags written with 0. Directed sequences test packet ready with a buffer that still holds packets and with a buffer holding only the packet being read, which separates the re-set from a plain hold. The read watchdog is probed one cycle before and at its expiry, and also with data arriving in time and with a read of a non-empty buffer. The DMA flag is tested with a write, with one enable dropped, with both enables dropped, and with an end-of-process strobe while DMA is disabled.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int STAT_W    = 8;
    localparam int LOW_W     = 5;
    localparam int BIT_PKT   = 7;
    localparam int BIT_RDERR = 6;
    localparam int BIT_DMA   = 5;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_WAIT   = 2'd1,
        W_EXPIRE = 2'd2
    } watch_st_e;
endpackage

// File: rtl/rxs_rd_watch.sv
module rxs_rd_watch
    import rxs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 269
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rd,
    input  logic buf_empty,
    output logic timeout_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

    watch_st_e state_q, state_d;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:   if (host_rd && buf_empty) state_d = W_WAIT;
            W_WAIT: begin
                if (!buf_empty)         state_d = W_IDLE;
                else if (cnt_q == LAST) state_d = W_EXPIRE;
            end
            W_EXPIRE: state_d = W_IDLE;
            default:  state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != W_WAIT) cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        timeout_o = (state_q == W_EXPIRE);
    end

    // R8
    expire_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == W_EXPIRE |=> state_q == W_IDLE);
    // R8
    ready_read_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_IDLE && host_rd && !buf_empty) |=> state_q == W_IDLE);
    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == W_WAIT |-> cnt_q < TW'(TIMEOUT_CYC));
endmodule

// File: rtl/rxs_pkt_ready.sv
module rxs_pkt_ready #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pkt_count,
    input  logic             clr_req,
    output logic             set_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= pkt_count;
            pend_q <= clr_req && (pkt_count > CNT_W'(1));
        end
    end

    always_comb begin
        set_o = (pkt_count > cnt_q) || pend_q;
    end

    // R7
    reassert_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && pkt_count > CNT_W'(1)) |=> set_o);
endmodule

// File: rtl/rxs_status.sv
module rxs_status
    import rxs_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TIMEOUT_CYC = 269
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pkt_count,
    input  logic             host_rd,
    input  logic             buf_empty,
    input  logic             dma_eop,
    input  logic             dma_rx_en,
    input  logic             dma_tx_en,
    input  logic [4:0]       ev_lo,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             mask_wr_en,
    input  logic [7:0]       mask_wr_data,
    output logic [7:0]       status_o,
    output logic [7:0]       mask_o,
    output logic             irq_o
);
    logic [STAT_W-1:0] stat_q, set_vec, clr_vec;
    logic [STAT_W-1:0] mask_q;
    logic              pkt_set, rd_timeout, dma_on;

    rxs_pkt_ready #(.CNT_W(CNT_W)) pkt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_count(pkt_count),
        .clr_req  (wr_en && wr_data[BIT_PKT]),
        .set_o    (pkt_set)
    );

    rxs_rd_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) watch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_rd  (host_rd),
        .buf_empty(buf_empty),
        .timeout_o(rd_timeout)
    );

    always_comb begin
        dma_on  = dma_rx_en || dma_tx_en;
        set_vec = {pkt_set, rd_timeout, dma_eop, ev_lo};
        clr_vec = wr_en ? wr_data : '0;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == BIT_DMA) begin : g_dma
            always_ff @(posedge clk) begin
                if (!rst_n) stat_q[i] <= 1'b0;
                else        stat_q[i] <= (stat_q[i] || set_vec[i]) && dma_on;
            end
        end else begin : g_w1c
            always_ff @(posedge clk) begin
                if (!rst_n) stat_q[i] <= 1'b0;
                else        stat_q[i] <= set_vec[i] || (stat_q[i] && !clr_vec[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '0;
        else if (mask_wr_en) mask_q <= mask_wr_data;
    end

    always_comb begin
        status_o = stat_q;
        mask_o   = mask_q;
        irq_o    = |(stat_q & mask_q);
    end

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && !ev_lo[0]) |=> !status_o[0]);
    // R2
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lo[1] |=> status_o[1]);
    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_lo[2] && wr_en && wr_data[2]) |=> status_o[2]);
    // R9
    dma_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_rx_en && !dma_tx_en) |=> !status_o[BIT_DMA]);
    // R9
    dma_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[BIT_DMA] && (dma_rx_en || dma_tx_en)) |=> status_o[BIT_DMA]);
    // R5
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == 8'h00) |-> !irq_o);
endmodule

// File: tb/rxs_status_tb.sv
module rxs_status_tb_top;
    localparam int CNT_W = 8;
    localparam int TO    = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] pkt_count;
    logic             host_rd, buf_empty, dma_eop, dma_rx_en, dma_tx_en;
    logic [4:0]       ev_lo;
    logic             wr_en, mask_wr_en;
    logic [7:0]       wr_data, mask_wr_data;
    logic [7:0]       status_o, mask_o;
    logic             irq_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rxs_status #(.CNT_W(CNT_W), .TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_count(pkt_count), .host_rd(host_rd),
        .buf_empty(buf_empty), .dma_eop(dma_eop), .dma_rx_en(dma_rx_en),
        .dma_tx_en(dma_tx_en), .ev_lo(ev_lo), .wr_en(wr_en), .wr_data(wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    function automatic logic [4:0] exp_low(logic [4:0] cur, logic [4:0] ev,
                                           logic we, logic [7:0] wd);
        return ev | (cur & ~(we ? wd[4:0] : 5'h00));
    endfunction

    function automatic logic exp_irq(logic [7:0] st, logic [7:0] mk);
        return |(st & mk);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [4:0] low;
        logic [7:0] mk;
        void'($urandom(32'd4242));
        rst_n = 0; pkt_count = '0; host_rd = 0; buf_empty = 1; dma_eop = 0;
        dma_rx_en = 1; dma_tx_en = 1; ev_lo = '0; wr_en = 0; wr_data = '0;
        mask_wr_en = 0; mask_wr_data = '0;
        @(negedge clk);
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk("R1 status", status_o, 8'h00);
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);

        // R2 R3 R5 random events, clears and masks on bits 4..0
        low = '0; mk = '0;
        for (int it = 0; it < 400; it++) begin
            ev_lo   = 5'($urandom) & 5'($urandom);
            wr_en   = ($urandom % 2) == 0;
            wr_data = 8'($urandom);
            mask_wr_en = ($urandom % 8) == 0;
            mask_wr_data = 8'($urandom);
            low = exp_low(low, ev_lo, wr_en, wr_data);
            if (mask_wr_en) mk = mask_wr_data;
            step(1);
            chk("R2/R3 status", status_o, {3'b000, low});
            chk("R5 irq", {7'b0, irq_o}, {7'b0, exp_irq({3'b000, low}, mk)});
        end
        ev_lo = '0; wr_en = 0; mask_wr_en = 0;

        // clear all, then R4 set beats clear
        wr_en = 1; wr_data = 8'hFF; step(1); wr_en = 0;
        chk("R3 clear all", status_o, 8'h00);
        ev_lo = 5'b00100; wr_en = 1; wr_data = 8'h04; step(1);
        ev_lo = '0; wr_en = 0;
        chk("R4 set wins", status_o, 8'h04);

        // R5 masking
        mask_wr_en = 1; mask_wr_data = 8'h03; step(1); mask_wr_en = 0;
        chk("R5 masked irq", {7'b0, irq_o}, 8'h00);
        mask_wr_en = 1; mask_wr_data = 8'h04; step(1); mask_wr_en = 0;
        chk("R5 enabled irq", {7'b0, irq_o}, 8'h01);
        wr_en = 1; wr_data = 8'h04; step(1); wr_en = 0;
        chk("R5 irq after clear", {7'b0, irq_o}, 8'h00);

        // R6 packet arrival
        pkt_count = 8'd1; step(1);
        chk("R6 arrival", status_o & 8'h80, 8'h80);
        pkt_count = 8'd3; step(1);
        // R7 clear with packets remaining
        wr_en = 1; wr_data = 8'h80; step(1); wr_en = 0;
        chk("R7 cleared cycle", status_o & 8'h80, 8'h00);
        pkt_count = 8'd2; step(1);
        chk("R7 re-set", status_o & 8'h80, 8'h80);
        pkt_count = 8'd1; step(1);
        wr_en = 1; wr_data = 8'h80; step(1); wr_en = 0;
        pkt_count = 8'd0;
        chk("R7 last packet clear", status_o & 8'h80, 8'h00);
        step(1);
        chk("R7 stays clear", status_o & 8'h80, 8'h00);

        // R8 read timeout
        buf_empty = 1; host_rd = 1; step(1); host_rd = 0;
        step(TO);
        chk("R8 before expiry", status_o & 8'h40, 8'h00);
        step(1);
        chk("R8 expiry", status_o & 8'h40, 8'h40);
        wr_en = 1; wr_data = 8'h40; step(1); wr_en = 0;
        chk("R8 cleared", status_o & 8'h40, 8'h00);
        host_rd = 1; step(1); host_rd = 0;
        step(3); buf_empty = 0; step(TO + 4);
        chk("R8 answered in time", status_o & 8'h40, 8'h00);
        host_rd = 1; step(1); host_rd = 0; buf_empty = 1;
        step(TO + 4);
        chk("R8 read of full buffer", status_o & 8'h40, 8'h00);

        // R9 DMA done
        dma_eop = 1; step(1); dma_eop = 0;
        chk("R9 eop set", status_o & 8'h20, 8'h20);
        wr_en = 1; wr_data = 8'h20; step(1); wr_en = 0;
        chk("R9 write ignored", status_o & 8'h20, 8'h20);
        dma_rx_en = 0; step(1);
        chk("R9 one enable low", status_o & 8'h20, 8'h20);
        dma_tx_en = 0; step(1);
        chk("R9 both low clear", status_o & 8'h20, 8'h00);
        dma_eop = 1; step(1); dma_eop = 0;
        chk("R9 eop while off", status_o & 8'h20, 8'h00);

        finish_run();
    end
endmodule